// File: doc/BRIEF.md
# Interrupt CPU-Target Register Bank

This block stores, for every interrupt line, an 8-bit mask naming the processors that the interrupt may be delivered to. The masks are reached through a simple synchronous register bus. Each 32-bit word of the bank holds the masks of four neighbouring interrupts. Either a whole word or single byte lanes can be accessed, and the lanes taking part are chosen by byte strobes. The full set of stored masks is also driven out on a flat bus, so that the downstream routing logic can use every interrupt's target set at the same moment.

Two elaboration parameters set the size of the bank. `NUM_CPU` (1 to 8) gives the number of processors that exist. In every byte, the mask bits for processors that do not exist are tied to zero: they read as zero and writes to them are dropped. `NUM_IRQ` (a multiple of 32, at most 1020) gives the number of interrupt lines. The bank begins at byte address 0x800 of the distributor space. Any bus address outside the implemented range reads as zero and ignores writes. Read data is registered, so it appears one cycle after the request.

Top module: `cpu_target_bank`

## Requirements
- R1: After reset every stored target byte is zero, the exported mask bus is all zero, and the read data output is zero.
- R2: In every byte lane, bits at positions NUM_CPU and above always read as zero and are never stored. A write of 0xFFFFFFFF to a word therefore reads back as ((1<<NUM_CPU)-1) repeated in all four lanes, which is 0x0F0F0F0F for NUM_CPU=4.
- R3: A word write with all four strobes set, followed by a read of the same word, returns the written value ANDed with the repeated processor mask. For example 0x0103020F reads back as 0x0103020F when NUM_CPU=4.
- R4: Interrupt n owns byte address 0x800+n. The word at address bits [11:2] covers interrupts 4k to 4k+3, and interrupt 4k+i sits in lane i, which is data bits [8i+7:8i]. Address bits [1:0] do not select anything; the strobes choose the lanes.
- R5: A write changes only the lanes whose strobe bit is 1. The other lanes of that word, and all other words, keep their values.
- R6: A read returns the masked stored byte in every lane whose strobe bit is 1, and zero in every lane whose strobe bit is 0.
- R7: An address below 0x800, or at or above 0x800+NUM_IRQ, reads as zero, and a write to it changes no stored byte.
- R8: Read data shows up on the output after the clock edge that samples the read request. It keeps that value through idle cycles and writes until the next read.
- R9: Export lane n (bits [8n+7:8n]) of the mask bus always equals interrupt n's stored byte. It changes on the same edge that takes the write.
- R10: A read issued in the cycle right after a write to the same word returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Bus access request this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte address in the distributor space |
| acc_strb | input | 4 | Byte lane strobes |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| tgt_mask | output | NUM_IRQ*8 | Target mask of every interrupt, interrupt n in bits [8n+7:8n] |

## Verification
Two functions can meet in one cycle. The mask bus and the storage take a write on an edge, and the very next cycle a read of that same word has to see the new content through the registered read path. The bench provokes this by issuing reads straight after writes, with no idle cycle, both in directed cases and across a long run of random mixed accesses. Each read is judged against a bench model that applies the lane masking and strobe selection itself. The full exported mask bus is compared with that model after every access.

// File: rtl/cpu_tgt_pkg.sv
package cpu_tgt_pkg;
    localparam int BANK_BASE = 'h800;
    localparam int ADDR_W    = 12;

    // Low byte holding one bit per existing processor
    function automatic logic [7:0] cpu_byte_mask(int ncpu);
        logic [8:0] m;
        m = (9'd1 << ncpu) - 9'd1;
        return m[7:0];
    endfunction

    // Expand 4 lane strobes into a 32-bit bit mask
    function automatic logic [31:0] lane_bits(logic [3:0] s);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[i*8 +: 8] = {8{s[i]}};
        return r;
    endfunction
endpackage

// File: rtl/cpu_tgt_decode.sv
module cpu_tgt_decode
    import cpu_tgt_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    localparam int WIDX = $clog2(NUM_IRQ / 4)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [WIDX-1:0]   widx
);
    logic [ADDR_W-1:0] off;
    logic              unused_bits;

    assign off  = addr - ADDR_W'(BANK_BASE);
    assign hit  = (addr >= ADDR_W'(BANK_BASE)) && (off < ADDR_W'(NUM_IRQ));
    assign widx = off[WIDX+1:2];
    assign unused_bits = ^{off[1:0], off[ADDR_W-1:WIDX+2]};
endmodule

// File: rtl/cpu_tgt_store.sv
module cpu_tgt_store
    import cpu_tgt_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    localparam int WIDX = $clog2(NUM_IRQ / 4),
    localparam int TW   = NUM_IRQ * 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WIDX-1:0] widx,
    input  logic [3:0]      strb,
    input  logic [31:0]     wdata,
    output logic [TW-1:0]   tgt
);
    localparam logic [7:0] LMASK = cpu_byte_mask(NUM_CPU);

    typedef struct packed {
        logic [TW-1:0] tgt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int l = 0; l < 4; l++) begin
                if (strb[l]) begin
                    st_d.tgt[(32'(widx) * 4 + l) * 8 +: 8] = wdata[l*8 +: 8] & LMASK;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgt = st_q.tgt;
endmodule

// File: rtl/cpu_target_bank.sv
module cpu_target_bank
    import cpu_tgt_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_en,
    input  logic                 acc_wr,
    input  logic [11:0]          acc_addr,
    input  logic [3:0]           acc_strb,
    input  logic [31:0]          acc_wdata,
    output logic [31:0]          acc_rdata,
    output logic [NUM_IRQ*8-1:0] tgt_mask
);
    localparam int WIDX = $clog2(NUM_IRQ / 4);

    typedef struct packed {
        logic [31:0] rdata;
    } rd_t;

    logic            hit;
    logic [WIDX-1:0] widx;
    logic [31:0]     word;
    rd_t             rd_d, rd_q;

    cpu_tgt_decode #(.NUM_IRQ(NUM_IRQ)) u_dec (
        .addr (acc_addr),
        .hit  (hit),
        .widx (widx)
    );

    cpu_tgt_store #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (acc_en && acc_wr && hit),
        .widx  (widx),
        .strb  (acc_strb),
        .wdata (acc_wdata),
        .tgt   (tgt_mask)
    );

    assign word = tgt_mask[32'(widx) * 32 +: 32];

    always_comb begin
        rd_d = rd_q;
        if (acc_en && !acc_wr) begin
            rd_d.rdata = hit ? (word & lane_bits(acc_strb)) : 32'h0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign acc_rdata = rd_q.rdata;
endmodule

// File: rtl/cpu_target_bank_chk.sv
module cpu_target_bank_chk
    import cpu_tgt_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 acc_en,
    input logic                 acc_wr,
    input logic [11:0]          acc_addr,
    input logic [3:0]           acc_strb,
    input logic [31:0]          acc_wdata,
    input logic [31:0]          acc_rdata,
    input logic [NUM_IRQ*8-1:0] tgt_mask
);
    localparam logic [NUM_IRQ*8-1:0] ALLOWED = {NUM_IRQ{cpu_byte_mask(NUM_CPU)}};

    logic in_bank;
    assign in_bank = (int'(acc_addr) >= BANK_BASE) && (int'(acc_addr) < BANK_BASE + NUM_IRQ);

    // R1: state is clear on the first cycle out of reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tgt_mask == '0 && acc_rdata == 32'h0));

    // R2: no exported bit above the processor count
    p_no_ghost_cpu_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_mask & ~ALLOWED) == '0);

    // R6: lanes without strobe read as zero
    p_unstrobed_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr) |=> ((acc_rdata & ~lane_bits($past(acc_strb))) == 32'h0));

    // R7: reads outside the bank return zero
    p_oob_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr && !in_bank) |=> (acc_rdata == 32'h0));

    // R7: writes outside the bank change nothing
    p_oob_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && !in_bank) |=> $stable(tgt_mask));

    // R8: read data holds when no read is issued
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_wr) |=> $stable(acc_rdata));

    // R9: the mask bus moves only on an accepted write
    p_export_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && acc_wr) |=> $stable(tgt_mask));
endmodule

bind cpu_target_bank cpu_target_bank_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_en),
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_strb  (acc_strb),
    .acc_wdata (acc_wdata),
    .acc_rdata (acc_rdata),
    .tgt_mask  (tgt_mask)
);

// File: tb/cpu_target_bank_test.sv
module cpu_target_bank_test;
    localparam int NIRQ = 64;
    localparam int NCPU = 4;
    localparam int BASE = 'h800;
    localparam logic [7:0] CMASK = 8'h0F;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                acc_en = 1'b0;
    logic                acc_wr = 1'b0;
    logic [11:0]         acc_addr = '0;
    logic [3:0]          acc_strb = '0;
    logic [31:0]         acc_wdata = '0;
    logic [31:0]         acc_rdata;
    logic [NIRQ*8-1:0]   tgt_mask;

    logic [7:0]  model [NIRQ];
    logic [31:0] last_rd;
    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    cpu_target_bank #(.NUM_IRQ(NIRQ), .NUM_CPU(NCPU)) uut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_strb(acc_strb), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .tgt_mask(tgt_mask)
    );

    function automatic bit in_range(logic [11:0] a);
        return (int'(a) >= BASE) && (int'(a) < BASE + NIRQ);
    endfunction

    function automatic logic [31:0] model_word(logic [11:0] a);
        int w;
        w = (int'(a) - BASE) / 4;
        return {model[w*4+3], model[w*4+2], model[w*4+1], model[w*4]};
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] a, logic [3:0] s);
        logic [31:0] r;
        if (!in_range(a)) return 32'h0;
        r = model_word(a);
        for (int i = 0; i < 4; i++) if (!s[i]) r[i*8 +: 8] = 8'h0;
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic check_export();
        int bad;
        bad = 0;
        for (int n = 0; n < NIRQ; n++) if (tgt_mask[n*8 +: 8] !== model[n]) bad++;
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL R9: export actual %0d mismatching lanes expected 0", bad);
        end
    endtask

    // Entered and left at a falling edge
    task automatic op(bit wr, logic [11:0] a, logic [3:0] s, logic [31:0] d, string req);
        logic [31:0] e;
        acc_en = 1'b1; acc_wr = wr; acc_addr = a; acc_strb = s; acc_wdata = d;
        e = exp_read(a, s);
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0;
        if (wr) begin
            if (in_range(a)) begin
                for (int i = 0; i < 4; i++)
                    if (s[i]) model[((int'(a) - BASE) / 4) * 4 + i] = d[i*8 +: 8] & CMASK;
            end
            check({req, " R8 hold"}, acc_rdata, last_rd);
        end else begin
            last_rd = e;
            check(req, acc_rdata, e);
        end
        check_export();
    endtask

    task automatic idle(int n);
        acc_en = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] a;
        void'($urandom(32'd1234));
        for (int n = 0; n < NIRQ; n++) model[n] = 8'h0;
        last_rd = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", acc_rdata, 32'h0);
        check_export();
        op(1'b0, 12'h80C, 4'hF, 0, "R1 read");

        // R2 all-ones write masked per lane
        op(1'b1, 12'h820, 4'hF, 32'hFFFF_FFFF, "R2 write");
        op(1'b0, 12'h820, 4'hF, 0, "R2 read");
        check("R2 value", acc_rdata, 32'h0F0F_0F0F);

        // R3 pattern word, R10 back-to-back read
        op(1'b1, 12'h820, 4'hF, 32'h0103_020F, "R3 write");
        op(1'b0, 12'h820, 4'hF, 0, "R10 read");
        check("R3 value", acc_rdata, 32'h0103_020F);

        // R6/R4 single byte read of interrupt 33
        op(1'b0, 12'h821, 4'b0010, 0, "R6 read");
        check("R4 byte", acc_rdata, 32'h0000_0200);

        // R5 byte write of interrupt 34
        op(1'b1, 12'h822, 4'b0100, 32'h0004_0000, "R5 write");
        op(1'b0, 12'h820, 4'hF, 0, "R5 read");
        check("R5 value", acc_rdata, 32'h0104_020F);

        // R7 out of range both sides
        op(1'b1, 12'(BASE + NIRQ), 4'hF, 32'hFFFF_FFFF, "R7 write high");
        op(1'b0, 12'(BASE + NIRQ), 4'hF, 0, "R7 read high");
        check("R7 high", acc_rdata, 32'h0);
        op(1'b1, 12'h7FC, 4'hF, 32'hFFFF_FFFF, "R7 write low");
        op(1'b0, 12'h7FC, 4'hF, 0, "R7 read low");
        check("R7 low", acc_rdata, 32'h0);

        // R4 last word of the bank
        op(1'b1, 12'(BASE + NIRQ - 4), 4'b1000, 32'h0900_0000, "R4 write top");
        op(1'b0, 12'(BASE + NIRQ - 1), 4'hF, 0, "R4 read top");
        check("R4 top", acc_rdata, 32'h0900_0000);

        // R8 hold across idle cycles
        idle(3);
        check("R8 idle", acc_rdata, last_rd);

        // Random mix
        for (int k = 0; k < 2000; k++) begin
            a = 12'(BASE - 16 + $urandom_range(0, NIRQ + 31));
            op(1'($urandom_range(0, 1)), a, 4'($urandom), $urandom, "R5 R6 random");
            if ($urandom_range(0, 7) == 0) idle(1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule